// File: doc/BRIEF.md
# System Clock Control Register with Deferred Apply

An 8-bit control register on a simple CPU write/read bus. It selects the system clock source, sets the divide ratio for the internal RC oscillator and controls the oscillator enables. It also decides whether the watchdog RC oscillator keeps running while the core is in stop mode. A bypass bit in each write decides when that write takes effect. With bypass set, a new source select and new oscillator stop bits take effect on the next clock. With bypass clear, they are held in a single pending slot and applied only when the core enters stop mode and later wakes.

The block also produces a one-cycle clock-enable pulse for the internal RC path. The pulse repeats every 1, 2, 4 or 8 cycles, which stands in for the divided system clock. A fuse input can lock the crystal oscillator off. Stop entry and wake-up arrive as single-cycle input pulses from the core's power sequencer.

Top module: `sysclk_ctrl`

## Requirements
- R1: After reset, reading the register gives 0x04, the active source select is 00, the RC enable is 1, the crystal enable is 0 and the watchdog-RC enable is 1.
- R2: The read value has this layout: bit 7 = keep watchdog RC running in stop, bits 6:5 = divide code, bit 4 = bypass, bit 3 = RC stop, bit 2 = crystal stop, bits 1:0 = source select. Reads return the last written value, with only the R6 override applied.
- R3: A write with bit 4 = 1 copies its select and stop bits to the active outputs on the next clock and discards any pending value. The outputs are rc_en = not RC stop and xtal_en = not crystal stop.
- R4: A write with bit 4 = 0 leaves the active select and oscillator enables unchanged. Its select and stop bits are applied in the cycle after a wake pulse that follows a stop-entry pulse.
- R5: Only the last bypass-clear write before the wake is applied. A wake pulse that arrives outside stop mode has no effect.
- R6: While fuse_xtal_ok is 0, read bit 2 is 1 and xtal_en is 0, whatever was written.
- R7: wdtrc_en is 1 outside stop mode. Between a stop-entry pulse and the next wake it equals bit 7.
- R8: When the active select is 00 (internal RC), clk_ce pulses once every 1, 2, 4 or 8 cycles for divide codes 00, 01, 10 and 11. For any other select (01 crystal, 1x watchdog RC), clk_ce is 1 in every cycle.
- R9: In the cycle in which the effective ratio changes, clk_ce is 0. The first pulse at the new ratio comes in the next cycle, so no pulse is cut short.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read value |
| stop_enter | input | 1 | Pulse: core enters stop mode |
| wake | input | 1 | Pulse: core wakes from stop mode |
| fuse_xtal_ok | input | 1 | 0 forces the crystal oscillator off |
| src_sel | output | 2 | Active clock source select |
| rc_en | output | 1 | Internal RC oscillator enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| wdtrc_en | output | 1 | Watchdog RC oscillator enable |
| clk_ce | output | 1 | Divided clock-enable pulse |

## Verification
The hardest state to reach from the ports is a pending value that has been overwritten several times and then applied by a real stop/wake pair. The stimulus stages two bypass-clear writes and sends a wake while not in stop, which must be ignored. It then sends stop, writes again during stop, and finally wakes. The bench also changes the divide code while the internal RC source is selected, so it can check the gap when the ratio changes and every ratio's pulse spacing. A reference model runs alongside and is compared on every cycle.

// File: rtl/sysclk_ctrl.sv
module sysclk_ctrl #(
  parameter int DIV_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stop_enter,
  input  logic       wake,
  input  logic       fuse_xtal_ok,
  output logic [1:0] src_sel,
  output logic       rc_en,
  output logic       xtal_en,
  output logic       wdtrc_en,
  output logic       clk_ce
);
  localparam int CW = (1 << DIV_W) - 1;

  logic             wons_q, byp_q, ist_q, xst_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       cs_q;
  logic [1:0]       act_cs, pnd_cs;
  logic             act_ist, act_xst, pnd_ist, pnd_xst, pnd_v, in_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wons_q <= 1'b0; div_q <= '0; byp_q <= 1'b0;
      ist_q <= 1'b0; xst_q <= 1'b1; cs_q <= 2'b00;
      act_cs <= 2'b00; act_ist <= 1'b0; act_xst <= 1'b1;
      pnd_cs <= 2'b00; pnd_ist <= 1'b0; pnd_xst <= 1'b1; pnd_v <= 1'b0;
      in_stop <= 1'b0;
    end else begin
      if (wake && in_stop) begin
        in_stop <= 1'b0;
        if (pnd_v) begin
          act_cs <= pnd_cs; act_ist <= pnd_ist; act_xst <= pnd_xst;
          pnd_v <= 1'b0;
        end
      end else if (stop_enter) begin
        in_stop <= 1'b1;
      end
      if (wr_en) begin
        {wons_q, div_q, byp_q, ist_q, xst_q, cs_q} <= wr_data;
        if (wr_data[4]) begin
          act_cs <= wr_data[1:0]; act_ist <= wr_data[3]; act_xst <= wr_data[2];
          pnd_v <= 1'b0;
        end else begin
          pnd_cs <= wr_data[1:0]; pnd_ist <= wr_data[3]; pnd_xst <= wr_data[2];
          pnd_v <= 1'b1;
        end
      end
    end
  end

  assign rd_data  = {wons_q, div_q, byp_q, ist_q, xst_q | ~fuse_xtal_ok, cs_q};
  assign src_sel  = act_cs;
  assign rc_en    = ~act_ist;
  assign xtal_en  = ~act_xst & fuse_xtal_ok;
  assign wdtrc_en = ~in_stop | wons_q;

  logic [DIV_W-1:0] eff, eff_q;
  logic [CW-1:0]    cnt, lim;

  assign eff = (act_cs == 2'b00) ? div_q : '0;
  assign lim = CW'((1 << eff_q) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eff_q <= '0;
      cnt   <= '0;
    end else if (eff != eff_q) begin
      eff_q <= eff;
      cnt   <= '0;
    end else begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  assign clk_ce = (eff == eff_q) && (cnt == '0);

  p_bypass_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[4]) |=> (src_sel == $past(wr_data[1:0])));

  p_staged_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && wr_data[4]) && !wake) |=> $stable(src_sel));

  p_fuse_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !fuse_xtal_ok |-> (!xtal_en && rd_data[2]));

  p_wdt_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wdtrc_en == 1'b0) |-> !rd_data[7]);

  p_full_rate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != 2'b00 && $past(src_sel) != 2'b00) |-> clk_ce);

endmodule

// File: tb/sim_sysclk_ctrl.sv
`timescale 1ns/1ps
module sim_sysclk_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic stop_enter = 1'b0, wake = 1'b0, fuse_xtal_ok = 1'b1;
  logic [7:0] rd_data;
  logic [1:0] src_sel;
  logic rc_en, xtal_en, wdtrc_en, clk_ce;

  always #2.5 clk = ~clk;

  sysclk_ctrl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .stop_enter(stop_enter), .wake(wake),
    .fuse_xtal_ok(fuse_xtal_ok), .src_sel(src_sel), .rc_en(rc_en),
    .xtal_en(xtal_en), .wdtrc_en(wdtrc_en), .clk_ce(clk_ce));

  int n_cmp = 0, n_bad = 0, cycles = 0;
  bit done = 0;

  int m_reg = 8'h04;
  int a_cs = 0, a_ist = 0, a_xst = 1;
  int p_cs = 0, p_ist = 0, p_xst = 1, p_v = 0, m_stop = 0;
  int prev_eff = 0, k = 0;

  function automatic int eff_now();
    return (a_cs == 0) ? ((m_reg >> 5) & 3) : 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_reg = 8'h04; a_cs = 0; a_ist = 0; a_xst = 1;
      p_cs = 0; p_ist = 0; p_xst = 1; p_v = 0; m_stop = 0; prev_eff = 0; k = 0;
    end else begin
      if (eff_now() != prev_eff) begin prev_eff = eff_now(); k = 0; end
      else k = (k + 1) % (1 << prev_eff);
      if (wake && m_stop == 1) begin
        m_stop = 0;
        if (p_v == 1) begin a_cs = p_cs; a_ist = p_ist; a_xst = p_xst; p_v = 0; end
      end else if (stop_enter) m_stop = 1;
      if (wr_en) begin
        m_reg = wr_data;
        if (wr_data[4]) begin a_cs = wr_data[1:0]; a_ist = wr_data[3]; a_xst = wr_data[2]; p_v = 0; end
        else begin p_cs = wr_data[1:0]; p_ist = wr_data[3]; p_xst = wr_data[2]; p_v = 1; end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2 R6 rd_data", rd_data, fuse_xtal_ok ? m_reg : (m_reg | 4));
      chk("R3 R4 R5 src_sel", src_sel, a_cs);
      chk("R3 rc_en", rc_en, a_ist ? 0 : 1);
      chk("R3 R6 xtal_en", xtal_en, (a_xst == 0 && fuse_xtal_ok) ? 1 : 0);
      chk("R7 wdtrc_en", wdtrc_en, (m_stop == 0 || m_reg[7]) ? 1 : 0);
      chk("R8 R9 clk_ce", clk_ce, (eff_now() == prev_eff && k == 0) ? 1 : 0);
    end
  end

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_enter = 1'b1; @(negedge clk); stop_enter = 1'b0;
  endtask
  task automatic pulse_wake();
    @(negedge clk); wake = 1'b1; @(negedge clk); wake = 1'b0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 reset read", rd_data, 8'h04);
    chk("R1 reset src", src_sel, 0);
    chk("R1 reset osc", {rc_en, xtal_en, wdtrc_en}, 3'b101);
    idle(4);
    wr(8'h11);                      // R3 bypass: crystal on, select 01
    idle(3);
    wr(8'h1A);                      // R3 select 10, RC off
    idle(3);
    wr(8'h02);                      // R4 staged
    wr(8'h09);                      // R5 overwrites staged
    pulse_wake();                   // R5 wake outside stop ignored
    idle(3);
    pulse_stop();
    idle(3);
    wr(8'h80);                      // R4 R7 staged during stop, keep WDT RC
    idle(3);
    pulse_wake();
    idle(3);
    wr(8'h30);                      // R8 RC source /2
    idle(16);
    wr(8'h50);                      // R9 change to /4
    idle(20);
    wr(8'h70);                      // R8 /8
    idle(30);
    wr(8'h10);                      // R9 back to /1
    idle(6);
    wr(8'h71);                      // R8 crystal source: div ignored
    idle(8);
    fuse_xtal_ok = 1'b0;            // R6 fuse lock
    idle(4);
    wr(8'h10);
    idle(3);
    fuse_xtal_ok = 1'b1;
    idle(3);
    wr(8'h40);                      // R7 stop with WDT RC off, staged /4
    pulse_stop();
    idle(5);
    pulse_wake();
    idle(12);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule